// File: doc/BRIEF.md
# Associative Register Rename Map

This block keeps the speculative and the committed register renaming state of an out-of-order core as a set of rows, one per physical register. Each row remembers which architectural register it was last allocated to and carries two flags: one says the row is the live (speculative) binding of that architectural register, the other says it is the committed binding. A source-operand lookup compares the requested architectural index against every live row at once and encodes the single matching row into a physical register index.

The rename stage writes a new binding by naming the architectural destination and the physical register chosen for it. This moves the live flag from the old row to the new one. When an instruction retires, its commit moves the committed flag in the same way. A recovery request, raised on a mispredicted branch or an exception, copies all committed flags onto the live flags in one clock. This discards every speculative binding without walking any history. Choosing free physical registers and tracking instruction order are left to neighbouring blocks.

Top module: `cam_rename_map`

## Requirements
- R1: After reset, architectural register i (0 to 2^AW-1) is bound to physical register i, both live and committed. No other row is live or committed.
- R2: With `lk_en` high, `lk_phys` gives the index of the live row whose stored architectural number equals `lk_arch`, and `lk_hit` is high when at least one live row matches.
- R3: A rename (`rn_en`) binds `rn_arch` to `rn_phys` from the next cycle on. It clears the live flag of the row that held `rn_arch` before.
- R4: A lookup of the architectural register being renamed in that same cycle returns the old binding.
- R5: A commit (`cm_en`) makes row `cm_phys` the committed binding of its stored architectural register. It clears the committed flag of any other row with that number, and it leaves live lookups unchanged.
- R6: A recovery (`rc_en`) replaces every live flag with the committed flags in one cycle. A rename raised in the same cycle is ignored.
- R7: When commit and recovery occur in the same cycle, the recovered state already includes that commit.
- R8: `lk_err` is high when `lk_en` is high and the number of matching live rows is not exactly one. It is low whenever `lk_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_en | input | 1 | Lookup request |
| lk_arch | input | AW | Architectural register to translate |
| lk_phys | output | PW | Encoded physical register of the match |
| lk_hit | output | 1 | At least one live row matched |
| lk_err | output | 1 | Zero or several live rows matched |
| rn_en | input | 1 | Rename request |
| rn_arch | input | AW | Architectural destination being renamed |
| rn_phys | input | PW | Physical register allocated to it |
| cm_en | input | 1 | Commit request |
| cm_phys | input | PW | Physical register whose binding retires |
| rc_en | input | 1 | Recover live state from committed state |

## Verification
The hardest state to reach from the ports is one where a lookup matches two live rows. Correct rename traffic never produces it. The stimulus gets there by renaming an architectural register onto a physical row that is still the committed home of a different register. That overwrites the row's stored number. A recovery then revives two committed rows that carry the same number. The empty-match case comes up on the way, because the displaced register loses its only live row. The run also hits a same-cycle commit plus recovery, and a rename raised during a recovery, and observes both through later lookups.

// File: rtl/cam_rename_map.sv
module cam_rename_map #(
  parameter int NPHYS = 128,
  parameter int AW    = 5,
  localparam int PW    = $clog2(NPHYS),
  localparam int NARCH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_en,
  input  logic [AW-1:0] lk_arch,
  output logic [PW-1:0] lk_phys,
  output logic          lk_hit,
  output logic          lk_err,
  input  logic          rn_en,
  input  logic [AW-1:0] rn_arch,
  input  logic [PW-1:0] rn_phys,
  input  logic          cm_en,
  input  logic [PW-1:0] cm_phys,
  input  logic          rc_en
);

  logic [AW-1:0]    arch_q [NPHYS];
  logic [NPHYS-1:0] cur_v, com_v, cur_d, com_d;
  logic [NPHYS-1:0] lk_match, rn_match, cm_match;
  logic [PW-1:0]    enc;
  logic [AW-1:0]    cm_arch;

  assign cm_arch = arch_q[cm_phys];

  always_comb begin
    for (int i = 0; i < NPHYS; i++) begin
      lk_match[i] = cur_v[i] && (arch_q[i] == lk_arch);
      rn_match[i] = cur_v[i] && (arch_q[i] == rn_arch);
      cm_match[i] = com_v[i] && (arch_q[i] == cm_arch);
    end
  end

  always_comb begin
    enc = '0;
    for (int i = 0; i < NPHYS; i++)
      if (lk_match[i]) enc = enc | PW'(i);
  end

  assign lk_phys = enc;
  assign lk_hit  = lk_en && (lk_match != '0);
  assign lk_err  = lk_en && ($countones(lk_match) != 1);

  assign com_d = cm_en ? ((com_v & ~cm_match) | (NPHYS'(1) << cm_phys)) : com_v;
  assign cur_d = rc_en ? com_d
               : rn_en ? ((cur_v & ~rn_match) | (NPHYS'(1) << rn_phys))
               : cur_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) begin
        arch_q[i] <= AW'(i);
        cur_v[i]  <= (i < NARCH);
        com_v[i]  <= (i < NARCH);
      end
    end else begin
      cur_v <= cur_d;
      com_v <= com_d;
      if (rn_en && !rc_en) arch_q[rn_phys] <= rn_arch;
    end
  end

  p_rename_binds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rn_en && !rc_en |=> cur_v[$past(rn_phys)] && (arch_q[$past(rn_phys)] == $past(rn_arch)));

  p_commit_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cm_en |=> com_v[$past(cm_phys)]);

  p_commit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cm_en |=> $stable(com_v));

  p_recover_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rc_en && !cm_en |=> cur_v == $past(com_v));

  p_idle_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |-> !lk_err);

  p_hit_when_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en && !lk_err |-> lk_hit);

endmodule

// File: tb/cam_rename_map_bench.sv
`timescale 1ns/1ps
module cam_rename_map_bench;
  localparam int NPHYS = 128;
  localparam int AW = 5;
  localparam int PW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_en = 1'b0, rn_en = 1'b0, cm_en = 1'b0, rc_en = 1'b0;
  logic [AW-1:0] lk_arch = '0, rn_arch = '0;
  logic [PW-1:0] rn_phys = '0, cm_phys = '0, lk_phys;
  logic lk_hit, lk_err;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  cam_rename_map #(.NPHYS(NPHYS), .AW(AW)) u_cam_rename_map (
    .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_arch(lk_arch),
    .lk_phys(lk_phys), .lk_hit(lk_hit), .lk_err(lk_err),
    .rn_en(rn_en), .rn_arch(rn_arch), .rn_phys(rn_phys),
    .cm_en(cm_en), .cm_phys(cm_phys), .rc_en(rc_en));

  // {op, arch, phys, expected phys, expected error}; op 0 lookup, 1 rename, 2 commit, 3 recover
  localparam int NV = 23;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 5'd3,  7'd0,   7'd3,   1'b0},  // R2 initial binding
    {2'd1, 5'd3,  7'd40,  7'd3,   1'b0},  // R4 same-cycle lookup sees old
    {2'd0, 5'd3,  7'd0,   7'd40,  1'b0},  // R3
    {2'd1, 5'd3,  7'd41,  7'd40,  1'b0},  // R4
    {2'd0, 5'd3,  7'd0,   7'd41,  1'b0},  // R3
    {2'd1, 5'd7,  7'd50,  7'd7,   1'b0},  // R4
    {2'd0, 5'd7,  7'd0,   7'd50,  1'b0},  // R3
    {2'd2, 5'd3,  7'd40,  7'd41,  1'b0},  // R5 commit leaves live view
    {2'd3, 5'd3,  7'd0,   7'd41,  1'b0},  // R6 pre-edge still speculative
    {2'd0, 5'd3,  7'd0,   7'd40,  1'b0},  // R6 recovered to committed
    {2'd0, 5'd7,  7'd0,   7'd7,   1'b0},  // R6 uncommitted rename dropped
    {2'd1, 5'd3,  7'd60,  7'd40,  1'b0},  // R3
    {2'd2, 5'd3,  7'd60,  7'd60,  1'b0},  // R5
    {2'd3, 5'd7,  7'd0,   7'd7,   1'b0},  // R6
    {2'd0, 5'd3,  7'd0,   7'd60,  1'b0},  // R5 commit survived recovery
    {2'd0, 5'd31, 7'd0,   7'd31,  1'b0},  // R1 top architectural index
    {2'd1, 5'd0,  7'd100, 7'd0,   1'b0},  // R4
    {2'd0, 5'd0,  7'd0,   7'd100, 1'b0},  // R3
    {2'd1, 5'd10, 7'd11,  7'd10,  1'b0},  // R3 rename onto committed row of arch 11
    {2'd0, 5'd11, 7'd0,   7'd0,   1'b1},  // R8 no live match
    {2'd0, 5'd10, 7'd0,   7'd11,  1'b0},  // R2
    {2'd3, 5'd10, 7'd0,   7'd11,  1'b0},  // R6
    {2'd0, 5'd10, 7'd0,   7'd0,   1'b1}   // R8 two live matches
  };

  task automatic drive(input logic rn, input logic cm, input logic rc,
                       input logic [AW-1:0] a, input logic [PW-1:0] p);
    @(negedge clk);
    rn_en = rn; cm_en = cm; rc_en = rc; lk_en = 1'b1;
    lk_arch = a; rn_arch = a; rn_phys = p; cm_phys = p;
    #1;
  endtask

  task automatic chk(input string req, input logic [PW-1:0] ep, input logic ee);
    checks++;
    if (ee ? (lk_err !== 1'b1) : (lk_err !== 1'b0 || lk_hit !== 1'b1 || lk_phys !== ep)) begin
      failures++;
      $display("FAIL %s arch=%0d: got phys=%0d hit=%0b err=%0b, expected phys=%0d err=%0b",
               req, lk_arch, lk_phys, lk_hit, lk_err, ep, ee);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rn_en = 0; cm_en = 0; rc_en = 0; lk_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    drive(0, 0, 0, 5'd31, '0); chk("R1", 7'd31, 1'b0);
    drive(0, 0, 0, 5'd0, '0);  chk("R1", 7'd0, 1'b0);

    for (int k = 0; k < NV; k++) begin
      logic [21:0] v;
      v = VEC[k];
      drive(v[21:20] == 2'd1, v[21:20] == 2'd2, v[21:20] == 2'd3, v[19:15], v[14:8]);
      chk($sformatf("vector %0d", k), v[7:1], v[0]);
    end

    drive(0, 0, 0, 5'd10, '0);
    lk_en = 1'b0; #0.5;
    checks++;
    if (lk_err !== 1'b0) begin
      failures++;
      $display("FAIL R8 idle lookup: got err=%0b, expected 0", lk_err);
    end

    do_reset();
    drive(0, 0, 0, 5'd3, '0);  chk("R1", 7'd3, 1'b0);
    drive(0, 0, 0, 5'd10, '0); chk("R1", 7'd10, 1'b0);

    drive(1, 0, 1, 5'd5, 7'd80);
    drive(0, 0, 0, 5'd5, '0);  chk("R6 rename during recover ignored", 7'd5, 1'b0);

    drive(1, 0, 0, 5'd4, 7'd70);
    drive(0, 1, 1, 5'd4, 7'd70);
    drive(0, 0, 0, 5'd4, '0);  chk("R7 commit with recover", 7'd70, 1'b0);

    drive(1, 0, 0, 5'd6, 7'd90);
    drive(0, 0, 1, 5'd6, '0);
    drive(0, 0, 0, 5'd6, '0);  chk("R6", 7'd6, 1'b0);

    @(negedge clk);
    rn_en = 0; cm_en = 0; rc_en = 0; lk_en = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule